// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms a 32-bit memory address from an already decoded addressing-mode code and the operands that go with it: a base register value, an index register value with a 2-bit shift amount, an instruction immediate field of selectable width and signedness, and the address of the next instruction. Five modes share one three-input adder. The immediate extender, the index scaler and the operand selection feed that adder, so absolute, pointer, displacement, scaled-array and branch-target addresses all take the same path.

A request is presented with a valid strobe. One clock later the block returns the address, a flag for a word access that is not on a 4-byte boundary, and a flag for an unknown mode code. Address arithmetic wraps modulo 2^32. The block does not access memory, does not write back to the register file and does not decode instructions.

Top module: `ea_gen`

## Requirements
- R1: A synchronous reset drives `valid_o` low. After reset, `valid_o` equals the value `valid_i` had at the previous rising clock edge.
- R2: Mode codes are 0 absolute, 1 register pointer, 2 base plus displacement, 3 base plus scaled index plus displacement, and 4 next-PC relative. Codes 5 to 7 set `illegal_o`, give an address of zero and clear `misalign_o`.
- R3: In absolute mode (0) the address is the selected immediate field zero-extended to 32 bits. `imm_signed_i` is ignored in this mode, and so are the `imm_i` bits above the selected width.
- R4: In register pointer mode (1) the address equals `base_i`.
- R5: In mode 2 the address is `base_i` plus the immediate field, which is sign-extended when `imm_signed_i` is 1 and zero-extended when it is 0. The width selector `imm_sel_i` picks the field width: 0 gives 8 bits, 1 gives 12, 2 gives 16 and 3 gives 20.
- R6: In mode 3 the address is `base_i` + (sign-extended 16-bit `index_i` shifted left by `scale_i`) + the immediate field extended as in R5.
- R7: In mode 4 the address is `pc_i` + 4 × (the immediate field, always sign-extended). `pc_i` already holds the next instruction address, and `imm_signed_i` is ignored.
- R8: All address sums wrap modulo 2^32 and give no overflow indication.
- R9: `size_i` encodes the access size: 0 byte, 1 halfword, 2 word, 3 treated as byte. `misalign_o` is 1 only when the access is a word access, the mode is legal and the address bits [1:0] are not zero.
- R10: The address and flag outputs change only on a clock edge where `valid_i` is 1. Otherwise they hold their last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 3 | Addressing-mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 16 | Index register value, signed |
| scale_i | input | 2 | Index shift amount |
| imm_i | input | 20 | Immediate / displacement / offset field |
| imm_sel_i | input | 2 | Field width select (8/12/16/20) |
| imm_signed_i | input | 1 | Field signedness for modes 2 and 3 |
| pc_i | input | 32 | Next instruction address |
| size_i | input | 2 | Access size code |
| valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Effective address |
| misalign_o | output | 1 | Unaligned word access |
| illegal_o | output | 1 | Unknown mode code |

## Verification
The bound properties assume that `rst` is held for at least one edge before any traffic. They also assume that every input is a known value on an edge where `valid_i` is 1, because they compare the output with the inputs sampled at that edge. The bench drives all inputs at the falling edge and keeps each request to a single cycle, so each request has exactly one sampling edge. The stimulus covers every mode code, including 5 to 7, every width selector, both signedness settings, negative indices and offsets, and sums chosen to cross zero and the top of the address space.

// File: rtl/ea_pkg.sv
package ea_pkg;
   typedef enum logic [2:0] {
      EA_ABS     = 3'd0,
      EA_PTR     = 3'd1,
      EA_BDISP   = 3'd2,
      EA_SCALED  = 3'd3,
      EA_PCREL   = 3'd4
   } ea_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } ea_size_e;

   localparam int NUM_FIELD_SEL = 4;
endpackage

// File: rtl/ea_field_ext.sv
module ea_field_ext #(
   parameter int IMM_W  = 20,
   parameter int ADDR_W = 32,
   parameter int FW0    = 8,
   parameter int FW1    = 12,
   parameter int FW2    = 16,
   parameter int FW3    = 20
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic [1:0]        sel,
   input  logic              sgn,
   output logic [ADDR_W-1:0] ext
);
   localparam int FW [ea_pkg::NUM_FIELD_SEL] = '{FW0, FW1, FW2, FW3};

   logic [ADDR_W-1:0] cand [ea_pkg::NUM_FIELD_SEL];

   for (genvar g = 0; g < ea_pkg::NUM_FIELD_SEL; g++) begin : g_width
      localparam int W = FW[g];
      logic fill;
      assign fill    = sgn & imm[W-1];
      assign cand[g] = {{(ADDR_W-W){fill}}, imm[W-1:0]};
   end

   assign ext = cand[sel];
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
   parameter int IDX_W        = 16,
   parameter int ADDR_W       = 32,
   parameter bit INDEX_SIGNED = 1'b1
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [1:0]        scale,
   output logic [ADDR_W-1:0] scaled
);
   logic [ADDR_W-1:0] wide;

   if (INDEX_SIGNED) begin : g_sext
      assign wide = {{(ADDR_W-IDX_W){idx[IDX_W-1]}}, idx};
   end else begin : g_zext
      assign wide = {{(ADDR_W-IDX_W){1'b0}}, idx};
   end

   always_comb begin
      unique case (scale)
         2'd0:    scaled = wide;
         2'd1:    scaled = {wide[ADDR_W-2:0], 1'b0};
         2'd2:    scaled = {wide[ADDR_W-3:0], 2'b00};
         default: scaled = {wide[ADDR_W-4:0], 3'b000};
      endcase
   end
endmodule

// File: rtl/ea_sum.sv
module ea_sum #(
   parameter int ADDR_W = 32
) (
   input  ea_pkg::ea_mode_e  mode,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] idx_scaled,
   input  logic [ADDR_W-1:0] fld_ext,
   output logic [ADDR_W-1:0] addr,
   output logic              illegal
);
   import ea_pkg::*;

   logic [ADDR_W-1:0] opa, opb, opc;

   always_comb begin
      opa     = '0;
      opb     = '0;
      opc     = '0;
      illegal = 1'b0;
      unique case (mode)
         EA_ABS:    opc = fld_ext;
         EA_PTR:    opa = base;
         EA_BDISP: begin
            opa = base;
            opc = fld_ext;
         end
         EA_SCALED: begin
            opa = base;
            opb = idx_scaled;
            opc = fld_ext;
         end
         EA_PCREL: begin
            opa = pc;
            opc = {fld_ext[ADDR_W-3:0], 2'b00};
         end
         default:   illegal = 1'b1;
      endcase
   end

   assign addr = opa + opb + opc;
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
   parameter int ADDR_W       = 32,
   parameter int IDX_W        = 16,
   parameter int IMM_W        = 20,
   parameter int FW0          = 8,
   parameter int FW1          = 12,
   parameter int FW2          = 16,
   parameter int FW3          = 20,
   parameter bit INDEX_SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              valid_i,
   input  logic [2:0]        mode_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IDX_W-1:0]  index_i,
   input  logic [1:0]        scale_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [1:0]        imm_sel_i,
   input  logic              imm_signed_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [1:0]        size_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              misalign_o,
   output logic              illegal_o
);
   import ea_pkg::*;

   localparam int WORD_LSB = 2;

   if (FW0 < 1 || FW1 < 1 || FW2 < 1 || FW3 < 1) begin : g_chk_fw_min
      $error("ea_gen: field widths must be positive");
   end
   if (FW0 > IMM_W || FW1 > IMM_W || FW2 > IMM_W || FW3 > IMM_W) begin : g_chk_fw_max
      $error("ea_gen: a field width exceeds IMM_W");
   end
   if (IMM_W + WORD_LSB >= ADDR_W) begin : g_chk_imm
      $error("ea_gen: IMM_W too wide for ADDR_W");
   end
   if (IDX_W + 3 > ADDR_W) begin : g_chk_idx
      $error("ea_gen: IDX_W too wide for ADDR_W");
   end

   ea_mode_e          mode;
   logic              sgn_eff;
   logic [ADDR_W-1:0] fld_ext;
   logic [ADDR_W-1:0] idx_scaled;
   logic [ADDR_W-1:0] sum;
   logic              bad_mode;
   logic              mis_c;

   assign mode = ea_mode_e'(mode_i);

   always_comb begin
      unique case (mode)
         EA_ABS:   sgn_eff = 1'b0;
         EA_PCREL: sgn_eff = 1'b1;
         default:  sgn_eff = imm_signed_i;
      endcase
   end

   ea_field_ext #(
      .IMM_W (IMM_W),
      .ADDR_W(ADDR_W),
      .FW0   (FW0),
      .FW1   (FW1),
      .FW2   (FW2),
      .FW3   (FW3)
   ) u_ext (
      .imm(imm_i),
      .sel(imm_sel_i),
      .sgn(sgn_eff),
      .ext(fld_ext)
   );

   ea_index_scale #(
      .IDX_W       (IDX_W),
      .ADDR_W      (ADDR_W),
      .INDEX_SIGNED(INDEX_SIGNED)
   ) u_idx (
      .idx   (index_i),
      .scale (scale_i),
      .scaled(idx_scaled)
   );

   ea_sum #(
      .ADDR_W(ADDR_W)
   ) u_sum (
      .mode      (mode),
      .base      (base_i),
      .pc        (pc_i),
      .idx_scaled(idx_scaled),
      .fld_ext   (fld_ext),
      .addr      (sum),
      .illegal   (bad_mode)
   );

   assign mis_c = !bad_mode && (ea_size_e'(size_i) == SZ_WORD) &&
                  (sum[WORD_LSB-1:0] != '0);

   always_ff @(posedge clk) begin
      if (rst) valid_o <= 1'b0;
      else     valid_o <= valid_i;
   end

   always_ff @(posedge clk) begin
      if (valid_i) begin
         addr_o     <= bad_mode ? '0 : sum;
         misalign_o <= mis_c;
         illegal_o  <= bad_mode;
      end
   end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 20
) (
   input logic              clk,
   input logic              rst,
   input logic              valid_i,
   input logic [2:0]        mode_i,
   input logic [ADDR_W-1:0] base_i,
   input logic [IMM_W-1:0]  imm_i,
   input logic [1:0]        imm_sel_i,
   input logic [1:0]        size_i,
   input logic              valid_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              misalign_o,
   input logic              illegal_o
);
   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
      valid_i |=> valid_o);

   assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> !valid_o);

   assert_illegal_zero_R2: assert property (@(posedge clk) disable iff (rst)
      valid_i && mode_i > 3'd4 |=> illegal_o && addr_o == '0 && !misalign_o);

   assert_abs_zext_R3: assert property (@(posedge clk) disable iff (rst)
      valid_i && mode_i == 3'd0 && imm_sel_i == 2'd3
      |=> addr_o == ADDR_W'($past(imm_i)) && !illegal_o);

   assert_ptr_base_R4: assert property (@(posedge clk) disable iff (rst)
      valid_i && mode_i == 3'd1 |=> addr_o == $past(base_i));

   assert_mis_only_word_R9: assert property (@(posedge clk) disable iff (rst)
      valid_i && size_i != 2'd2 |=> !misalign_o);

   assert_mis_word_R9: assert property (@(posedge clk) disable iff (rst)
      valid_i && size_i == 2'd2 && mode_i <= 3'd4
      |=> misalign_o == (addr_o[1:0] != 2'b00));

   assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !valid_i |=> $stable(addr_o) && $stable(misalign_o) && $stable(illegal_o));
endmodule

bind ea_gen ea_gen_chk #(
   .ADDR_W(ADDR_W),
   .IMM_W (IMM_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .valid_i   (valid_i),
   .mode_i    (mode_i),
   .base_i    (base_i),
   .imm_i     (imm_i),
   .imm_sel_i (imm_sel_i),
   .size_i    (size_i),
   .valid_o   (valid_o),
   .addr_o    (addr_o),
   .misalign_o(misalign_o),
   .illegal_o (illegal_o)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        valid_i = 1'b0;
   logic [2:0]  mode_i = '0;
   logic [31:0] base_i = '0;
   logic [15:0] index_i = '0;
   logic [1:0]  scale_i = '0;
   logic [19:0] imm_i = '0;
   logic [1:0]  imm_sel_i = '0;
   logic        imm_signed_i = 1'b0;
   logic [31:0] pc_i = '0;
   logic [1:0]  size_i = '0;
   logic        valid_o;
   logic [31:0] addr_o;
   logic        misalign_o;
   logic        illegal_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      logic [31:0] a;
      logic        m;
      logic        il;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ea_gen uut (
      .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
      .base_i(base_i), .index_i(index_i), .scale_i(scale_i), .imm_i(imm_i),
      .imm_sel_i(imm_sel_i), .imm_signed_i(imm_signed_i), .pc_i(pc_i),
      .size_i(size_i), .valid_o(valid_o), .addr_o(addr_o),
      .misalign_o(misalign_o), .illegal_o(illegal_o)
   );

   function automatic logic [31:0] fext(logic [19:0] f, int sel, bit s);
      int w;
      logic [31:0] m, v;
      w = (sel == 0) ? 8 : (sel == 1) ? 12 : (sel == 2) ? 16 : 20;
      m = (32'h1 << w) - 32'h1;
      v = {12'h0, f} & m;
      if (s && v[w-1]) v = v | ~m;
      return v;
   endfunction

   task automatic drive(input int md, input logic [31:0] b, input logic [15:0] ix,
                        input int sc, input logic [19:0] im, input int sel,
                        input bit sg, input logic [31:0] pc, input int sz,
                        input string req);
      exp_t e;
      logic [31:0] sidx;
      sidx = {{16{ix[15]}}, ix};
      e.il = 1'b0;
      case (md)
         0:       e.a = fext(im, sel, 1'b0);
         1:       e.a = b;
         2:       e.a = b + fext(im, sel, sg);
         3:       e.a = b + (sidx << sc) + fext(im, sel, sg);
         4:       e.a = pc + (fext(im, sel, 1'b1) << 2);
         default: begin e.a = 32'h0; e.il = 1'b1; end
      endcase
      e.m = !e.il && (sz == 2) && (e.a[1:0] != 2'b00);
      e.req = req;
      @(negedge clk);
      valid_i      = 1'b1;
      mode_i       = 3'(md);
      base_i       = b;
      index_i      = ix;
      scale_i      = 2'(sc);
      imm_i        = im;
      imm_sel_i    = 2'(sel);
      imm_signed_i = sg;
      pc_i         = pc;
      size_i       = 2'(sz);
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      valid_i = 1'b0;
      mode_i  = 3'd1;
      base_i  = 32'hDEAD_BEEF;
      size_i  = 2'd2;
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (!rst && valid_o) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R1 unexpected valid_o", 32'h1, 32'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(addr_o == e.a, {e.req, " addr"}, addr_o, e.a);
            chk(misalign_o == e.m, {e.req, " misalign"}, 32'(misalign_o), 32'(e.m));
            chk(illegal_o == e.il, {e.req, " illegal"}, 32'(illegal_o), 32'(e.il));
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(valid_o == 1'b0, "R1 reset", 32'(valid_o), 32'h0);
      rst = 1'b0;
      @(negedge clk);
      chk(valid_o == 1'b0, "R1 idle after reset", 32'(valid_o), 32'h0);

      drive(0, 32'h0, 16'h0, 0, 20'hFFFFF, 3, 1'b1, 32'h0, 0, "R3 abs 20b");
      drive(0, 32'h0, 16'h0, 0, 20'hABC80, 0, 1'b1, 32'h0, 0, "R3 abs 8b");
      drive(1, 32'h1234_5678, 16'h0, 0, 20'h0, 0, 1'b0, 32'h0, 2, "R4 ptr aligned");
      drive(1, 32'h0000_1001, 16'h0, 0, 20'h0, 0, 1'b0, 32'h0, 2, "R9 word odd");
      drive(1, 32'h0000_1001, 16'h0, 0, 20'h0, 0, 1'b0, 32'h0, 1, "R9 half odd");
      drive(1, 32'h0000_1002, 16'h0, 0, 20'h0, 0, 1'b0, 32'h0, 3, "R9 rsvd size");
      drive(2, 32'h0001_0000, 16'h0, 0, 20'h00FFF, 1, 1'b1, 32'h0, 0, "R5 12b signed");
      drive(2, 32'h0001_0000, 16'h0, 0, 20'h00FFF, 1, 1'b0, 32'h0, 0, "R5 12b unsigned");
      drive(2, 32'h7FFF_F000, 16'h0, 0, 20'h00080, 0, 1'b1, 32'h0, 2, "R5 8b -128");
      drive(2, 32'h0000_4000, 16'h0, 0, 20'h000F0, 0, 1'b1, 32'h0, 0, "R5 8b -16");
      drive(2, 32'h0000_4000, 16'h0, 0, 20'h08000, 2, 1'b1, 32'h0, 2, "R5 16b neg");
      drive(3, 32'h0000_4000, 16'hFFFC, 0, 20'h0, 0, 1'b0, 32'h0, 2, "R6 neg index");
      drive(3, 32'h0000_1000, 16'h0003, 2, 20'h00008, 0, 1'b1, 32'h0, 2, "R6 scale4");
      drive(3, 32'h0010_0000, 16'h8000, 3, 20'h0, 0, 1'b0, 32'h0, 0, "R6 scale8 min");
      drive(3, 32'h0000_2000, 16'h0005, 1, 20'hFFFFF, 3, 1'b1, 32'h0, 1, "R6 scale2 disp");
      drive(4, 32'h0, 16'h0, 0, 20'h0FFFD, 2, 1'b0, 32'h0000_1000, 2, "R7 back 3 words");
      drive(4, 32'h0, 16'h0, 0, 20'h0007F, 0, 1'b0, 32'h0000_2000, 2, "R7 fwd max 8b");
      drive(4, 32'h0, 16'h0, 0, 20'h800FF, 0, 1'b0, 32'h0000_0000, 0, "R8 pcrel wrap");
      drive(2, 32'hFFFF_FFF0, 16'h0, 0, 20'h00020, 0, 1'b0, 32'h0, 2, "R8 base wrap");
      drive(5, 32'h0000_1001, 16'h0, 0, 20'h12345, 3, 1'b1, 32'h1, 2, "R2 code5");
      drive(6, 32'h0000_1001, 16'h0, 0, 20'h12345, 3, 1'b1, 32'h1, 2, "R2 code6");
      drive(7, 32'h0000_1003, 16'h0, 0, 20'h12345, 3, 1'b1, 32'h1, 2, "R2 code7");
      drive(2, 32'h0000_0100, 16'h0, 0, 20'h00006, 0, 1'b0, 32'h0, 2, "R10 last");
      idle();
      idle();
      idle();
      // R10: the design must still show the last result (0x106, misaligned word)
      chk(addr_o == 32'h0000_0106, "R10 hold addr", addr_o, 32'h0000_0106);
      chk(misalign_o == 1'b1, "R10 hold misalign", 32'(misalign_o), 32'h1);
      chk(valid_o == 1'b0, "R1 valid low when idle", 32'(valid_o), 32'h0);
      chk(sb.size() == 0, "R1 all results returned", 32'(sb.size()), 32'h0);

      rst = 1'b1;
      @(negedge clk);
      chk(valid_o == 1'b0, "R1 reset mid-run", 32'(valid_o), 32'h0);
      rst = 1'b0;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule